// File: doc/BRIEF.md
# Two-Entry Receive Character Buffer with Per-Character Status

This block sits between a serial receiver front end and a register read port. The front end hands it each finished character: a low data byte, a ninth data bit, and that character's frame-error and parity-error results. The buffer holds two such characters. A third character can sit in a one-character waiting stage, standing in for the receiver's shift register, until one of the two entries frees up.

Software reads the buffer through two strobes. The status strobe copies the oldest character's ninth bit and error flags into the read-return outputs and leaves the buffer unchanged. The data strobe copies the oldest character's low byte and then removes that character. For this reason the status of a character must be read before its data byte. A receive-complete output shows whether any unread character is held.

If a new start bit is detected while both entries are full and a character is already waiting, the waiting character is lost. The overrun is then recorded on the newest buffered entry and is reported when that entry's status is read. Clearing the receiver enable empties the entries and the waiting stage.

Top module: `rx_char_fifo`

## Requirements
- R1: Up to two characters are held in arrival order, plus one in the waiting stage. The waiting character enters an entry at the same clock edge at which a data read frees one, and it is read back after the characters that arrived before it.
- R2: `rxComplete` is 1 from the edge that accepts a character into an empty buffer until the edge of the data read that removes the last held character. It is 0 whenever no unread character is held.
- R3: A `dataRead` pulse puts the oldest character's low byte on `rdData` at the next edge and removes that character. With the buffer empty, `rdData` becomes 0 and nothing else changes.
- R4: A `statusRead` pulse loads `rdBit8`, `rdFrameErr`, `rdParityErr` and `rdOverrun` from the oldest character at the next edge and does not remove it. Repeated status reads return the same values until a data read.
- R5: Error flags and the ninth bit travel with their own character. After a data read, the next status read returns the following character's values.
- R6: `startDetect` in a cycle with both entries full, a character waiting and no data read discards the waiting character. It also sets the overrun flag of the newest entry, and a status read of that entry shows `rdOverrun` = 1. A later entry written into that slot starts with overrun 0.
- R7: While `rxEnable` is 0, the buffer and waiting stage are emptied at each edge, `rxComplete` reads 0 after the first such edge, and `charValid` and `startDetect` are ignored. A status read of the empty buffer returns all zeros.
- R8: `startDetect` has no effect when no character is waiting, or when it coincides with a data read that frees an entry.
- R9: After reset, `rxComplete` and all read-return outputs are 0.
- R10: The read-return outputs change only at an edge where their own strobe was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| rxEnable | input | 1 | Receiver enable; 0 flushes the buffer |
| charValid | input | 1 | One-cycle pulse: a finished character is presented |
| charData | input | 8 | Low data byte of the presented character |
| charBit8 | input | 1 | Ninth data bit of the presented character |
| charFrameErr | input | 1 | Stop bit of the presented character was 0 |
| charParityErr | input | 1 | Parity check of the presented character failed |
| startDetect | input | 1 | One-cycle pulse: the front end saw a new start bit |
| statusRead | input | 1 | Status read strobe (ninth bit and flags), no pop |
| dataRead | input | 1 | Data read strobe; pops the oldest character |
| rxComplete | output | 1 | At least one unread character is held |
| rdData | output | 8 | Read-return low byte |
| rdBit8 | output | 1 | Read-return ninth bit |
| rdFrameErr | output | 1 | Read-return frame error |
| rdParityErr | output | 1 | Read-return parity error |
| rdOverrun | output | 1 | Read-return overrun |

## Verification
The properties assume the front end never presents a character while one is already waiting, and never raises `charValid` and `startDetect` in the same cycle, as a real shift register would behave. With that assumption, `rxComplete` can only rise after an accepted character and can only fall after a data read or a disabled cycle. The bench's behavioural model tracks whether a character is waiting. The random phase raises `charValid` only when the model holds no waiting character, and it picks at most one of the two front-end pulses per cycle. Status and data reads are drawn freely, including reads of an empty buffer.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  localparam int DATA_W = 8;

  // One buffered character with the status that travels with it.
  typedef struct packed {
    logic              frameErr;
    logic              parityErr;
    logic              bit8;
    logic [DATA_W-1:0] data;
  } rxqChar_t;

  // Strobes from control to datapath, valid for the current cycle.
  typedef struct packed {
    logic flush;       // receiver disabled: drop everything
    logic wrEn;        // write one entry this cycle
    logic wrFromHold;  // source of that write is the waiting stage
    logic holdLoad;    // park the incoming character in the waiting stage
    logic ovrSet;      // mark the newest entry as overrun
    logic capStatus;   // load read-return status registers
    logic capData;     // load read-return data register
    logic headValid;   // oldest entry holds an unread character
  } rxqStrobes_t;

endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH = 2,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxEnable,
  input  logic             charValid,
  input  logic             startDetect,
  input  logic             statusRead,
  input  logic             dataRead,
  output rxqStrobes_t      strb,
  output logic [IDX_W-1:0] wrIdx,
  output logic [IDX_W-1:0] ovrIdx,
  output logic [IDX_W-1:0] headIdx,
  output logic             rxComplete
);

  logic [CNT_W-1:0] count;
  logic [IDX_W-1:0] head;
  logic             holdValid;

  logic             pop;
  logic             isFull;
  logic             roomAfter;
  logic             moveHold;
  logic             directIn;
  logic             parkIn;
  logic             overrun;
  logic [CNT_W-1:0] afterPop;

  function automatic logic [IDX_W-1:0] wrapAdd(input logic [IDX_W-1:0] base,
                                               input logic [CNT_W-1:0] off);
    int s;
    s = int'(base) + int'(off);
    if (s >= DEPTH) s = s - DEPTH;
    return IDX_W'(s);
  endfunction

  always_comb begin
    isFull    = (count == CNT_W'(DEPTH));
    pop       = dataRead && (count != '0);
    afterPop  = count - CNT_W'(pop);
    roomAfter = (afterPop < CNT_W'(DEPTH));
    moveHold  = holdValid && roomAfter;
    directIn  = charValid && !holdValid && roomAfter;
    parkIn    = charValid && !holdValid && !roomAfter;
    overrun   = startDetect && holdValid && isFull && !pop;
  end

  always_comb begin
    strb            = '0;
    strb.flush      = !rxEnable;
    strb.wrEn       = rxEnable && (moveHold || directIn);
    strb.wrFromHold = moveHold;
    strb.holdLoad   = rxEnable && parkIn;
    strb.ovrSet     = rxEnable && overrun;
    strb.capStatus  = statusRead;
    strb.capData    = dataRead;
    strb.headValid  = (count != '0);
  end

  assign wrIdx      = wrapAdd(head, count);
  assign ovrIdx     = wrapAdd(head, count - CNT_W'(1));
  assign headIdx    = head;
  assign rxComplete = (count != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count     <= '0;
      head      <= '0;
      holdValid <= 1'b0;
    end else if (!rxEnable) begin
      count     <= '0;
      head      <= '0;
      holdValid <= 1'b0;
    end else begin
      count <= afterPop + CNT_W'(strb.wrEn);
      if (pop) head <= wrapAdd(head, CNT_W'(1));
      if (overrun || moveHold) holdValid <= 1'b0;
      else if (parkIn)         holdValid <= 1'b1;
    end
  end

endmodule

// File: rtl/rxq_datapath.sv
module rxq_datapath
  import rxq_pkg::*;
#(
  parameter int DEPTH = 2,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxqStrobes_t       strb,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [IDX_W-1:0]  ovrIdx,
  input  logic [IDX_W-1:0]  headIdx,
  input  rxqChar_t          inChar,
  output logic [DATA_W-1:0] rdData,
  output logic              rdBit8,
  output logic              rdFrameErr,
  output logic              rdParityErr,
  output logic              rdOverrun
);

  rxqChar_t             holdChar;
  rxqChar_t             writeChar;
  rxqChar_t             slotChar [DEPTH];
  logic     [DEPTH-1:0] slotOvr;
  logic     [DEPTH-1:0] slotWe;
  logic     [DEPTH-1:0] slotMark;
  rxqChar_t             headChar;
  logic                 headOvr;

  assign writeChar = strb.wrFromHold ? holdChar : inChar;

  // Waiting stage: the character the shift register still holds.
  always_ff @(posedge clk) begin
    if (!rstN)              holdChar <= '0;
    else if (strb.holdLoad) holdChar <= inChar;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    rxqChar_t charQ;
    logic     ovrQ;

    assign slotWe[g]   = strb.wrEn && (wrIdx == IDX_W'(g));
    assign slotMark[g] = strb.ovrSet && (ovrIdx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN)          charQ <= '0;
      else if (slotWe[g]) charQ <= writeChar;
    end

    // Overrun flag belongs to this entry; a fresh write starts it clear.
    always_ff @(posedge clk) begin
      if (!rstN)            ovrQ <= 1'b0;
      else if (strb.flush)  ovrQ <= 1'b0;
      else if (slotWe[g])   ovrQ <= 1'b0;
      else if (slotMark[g]) ovrQ <= 1'b1;
    end

    assign slotChar[g] = charQ;
    assign slotOvr[g]  = ovrQ;
  end

  assign headChar = slotChar[headIdx];
  assign headOvr  = slotOvr[headIdx];

  // Read-return registers, loaded only by their own strobe.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdBit8      <= 1'b0;
      rdFrameErr  <= 1'b0;
      rdParityErr <= 1'b0;
      rdOverrun   <= 1'b0;
    end else if (strb.capStatus) begin
      rdBit8      <= strb.headValid && headChar.bit8;
      rdFrameErr  <= strb.headValid && headChar.frameErr;
      rdParityErr <= strb.headValid && headChar.parityErr;
      rdOverrun   <= strb.headValid && headOvr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             rdData <= '0;
    else if (strb.capData) rdData <= strb.headValid ? headChar.data : '0;
  end

endmodule

// File: rtl/rx_char_fifo.sv
module rx_char_fifo
  import rxq_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxEnable,
  input  logic              charValid,
  input  logic [DATA_W-1:0] charData,
  input  logic              charBit8,
  input  logic              charFrameErr,
  input  logic              charParityErr,
  input  logic              startDetect,
  input  logic              statusRead,
  input  logic              dataRead,
  output logic              rxComplete,
  output logic [DATA_W-1:0] rdData,
  output logic              rdBit8,
  output logic              rdFrameErr,
  output logic              rdParityErr,
  output logic              rdOverrun
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  rxqStrobes_t      strb;
  logic [IDX_W-1:0] wrIdx;
  logic [IDX_W-1:0] ovrIdx;
  logic [IDX_W-1:0] headIdx;
  rxqChar_t         inChar;

  assign inChar.frameErr  = charFrameErr;
  assign inChar.parityErr = charParityErr;
  assign inChar.bit8      = charBit8;
  assign inChar.data      = charData;

  rxq_ctrl #(.DEPTH(DEPTH)) ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .rxEnable   (rxEnable),
    .charValid  (charValid),
    .startDetect(startDetect),
    .statusRead (statusRead),
    .dataRead   (dataRead),
    .strb       (strb),
    .wrIdx      (wrIdx),
    .ovrIdx     (ovrIdx),
    .headIdx    (headIdx),
    .rxComplete (rxComplete)
  );

  rxq_datapath #(.DEPTH(DEPTH)) dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wrIdx      (wrIdx),
    .ovrIdx     (ovrIdx),
    .headIdx    (headIdx),
    .inChar     (inChar),
    .rdData     (rdData),
    .rdBit8     (rdBit8),
    .rdFrameErr (rdFrameErr),
    .rdParityErr(rdParityErr),
    .rdOverrun  (rdOverrun)
  );

endmodule

// File: rtl/rx_char_fifo_chk.sv
module rx_char_fifo_chk (
  input logic       clk,
  input logic       rstN,
  input logic       rxEnable,
  input logic       charValid,
  input logic       statusRead,
  input logic       dataRead,
  input logic       rxComplete,
  input logic [7:0] rdData,
  input logic       rdBit8,
  input logic       rdFrameErr,
  input logic       rdParityErr,
  input logic       rdOverrun
);

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> !rxComplete);  // R7

  AST_COMPLETE_NEEDS_CHAR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxComplete) |-> ($past(charValid) && $past(rxEnable)));  // R2

  AST_EMPTY_NEEDS_READ: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxComplete) |-> ($past(dataRead) || !$past(rxEnable)));  // R3

  AST_EMPTY_STATUS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && !rxComplete) |=>
      !(rdBit8 || rdFrameErr || rdParityErr || rdOverrun));  // R7

  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(dataRead) |-> $stable(rdData));  // R10

  AST_STATUS_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(statusRead) |-> $stable({rdBit8, rdFrameErr, rdParityErr, rdOverrun}));  // R10

endmodule

bind rx_char_fifo rx_char_fifo_chk chk (
  .clk        (clk),
  .rstN       (rstN),
  .rxEnable   (rxEnable),
  .charValid  (charValid),
  .statusRead (statusRead),
  .dataRead   (dataRead),
  .rxComplete (rxComplete),
  .rdData     (rdData),
  .rdBit8     (rdBit8),
  .rdFrameErr (rdFrameErr),
  .rdParityErr(rdParityErr),
  .rdOverrun  (rdOverrun)
);

// File: tb/rx_char_fifo_test.sv
`timescale 1ns/1ps
module rx_char_fifo_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxEnable = 1'b1;
  logic       charValid = 1'b0;
  logic [7:0] charData = 8'h00;
  logic       charBit8 = 1'b0;
  logic       charFrameErr = 1'b0;
  logic       charParityErr = 1'b0;
  logic       startDetect = 1'b0;
  logic       statusRead = 1'b0;
  logic       dataRead = 1'b0;
  logic       rxComplete;
  logic [7:0] rdData;
  logic       rdBit8, rdFrameErr, rdParityErr, rdOverrun;

  int    checks = 0;
  int    errors = 0;
  bit    checking = 1'b0;
  bit    done = 1'b0;
  string curReq = "R9";

  always #2 clk = ~clk;

  rx_char_fifo uut (.*);

  // Behavioural reference: word = {ovr, parity, frame, bit8, data}
  bit [11:0] mq[$];
  bit        mHold = 1'b0;
  bit [11:0] mHoldW = '0;
  bit [7:0]  mData = '0;
  bit [3:0]  mStat = '0;

  always @(posedge clk) begin
    bit holdAtStart;
    bit popped;
    if (!rstN) begin
      mq.delete();
      mHold = 1'b0;
      mData = '0;
      mStat = '0;
    end else begin
      holdAtStart = mHold;
      if (statusRead) mStat = (mq.size() > 0) ? mq[0][11:8] : 4'h0;
      if (dataRead)   mData = (mq.size() > 0) ? mq[0][7:0] : 8'h00;
      if (!rxEnable) begin
        mq.delete();
        mHold = 1'b0;
      end else begin
        popped = dataRead && (mq.size() > 0);
        if (popped) void'(mq.pop_front());
        if (mHold && mq.size() < 2) begin
          mq.push_back(mHoldW);
          mHold = 1'b0;
        end else if (startDetect && mHold) begin
          mq[1][11] = 1'b1;   // overrun lands on the newest entry
          mHold = 1'b0;
        end
        if (charValid && !holdAtStart) begin
          if (mq.size() < 2) mq.push_back({1'b0, charParityErr, charFrameErr, charBit8, charData});
          else begin
            mHold  = 1'b1;
            mHoldW = {1'b0, charParityErr, charFrameErr, charBit8, charData};
          end
        end
      end
    end
  end

  // Cycle-by-cycle comparison against the model.
  always @(negedge clk) begin
    logic [12:0] act, exp;
    if (checking) begin
      act = {rxComplete, rdOverrun, rdParityErr, rdFrameErr, rdBit8, rdData};
      exp = {mq.size() > 0, mStat, mData};
      checks++;
      if (act !== exp) begin
        errors++;
        $display("FAIL %s: model compare actual=%h expected=%h at %0t", curReq, act, exp, $time);
      end
    end
  end

  task automatic checkVal(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic putChar(input logic [7:0] d, input logic b8, input logic fe, input logic pe);
    charValid = 1'b1; charData = d; charBit8 = b8; charFrameErr = fe; charParityErr = pe;
    @(negedge clk);
    charValid = 1'b0;
  endtask

  task automatic readStat();
    statusRead = 1'b1;
    @(negedge clk);
    statusRead = 1'b0;
  endtask

  task automatic readData();
    dataRead = 1'b1;
    @(negedge clk);
    dataRead = 1'b0;
  endtask

  task automatic startBit();
    startDetect = 1'b1;
    @(negedge clk);
    startDetect = 1'b0;
  endtask

  // status word {ovr, parity, frame, bit8}
  function automatic logic [15:0] statusNow();
    return {12'h0, rdOverrun, rdParityErr, rdFrameErr, rdBit8};
  endfunction

  initial begin
    int unsigned seed;
    logic [7:0] keep;
    seed = 32'h1234_5678;
    repeat (3) @(negedge clk);
    checking = 1'b1;
    checkVal("R9", {15'h0, rxComplete}, 16'h0);
    checkVal("R9", {8'h0, rdData}, 16'h0);
    checkVal("R9", statusNow(), 16'h0);
    rstN = 1'b1;
    @(negedge clk);

    // Single character
    curReq = "R2";
    putChar(8'hA5, 1'b1, 1'b0, 1'b0);
    checkVal("R2", {15'h0, rxComplete}, 16'h1);
    curReq = "R4";
    readStat();
    checkVal("R4", statusNow(), 16'h1);
    curReq = "R3";
    readData();
    checkVal("R3", {8'h0, rdData}, 16'h00A5);
    checkVal("R2", {15'h0, rxComplete}, 16'h0);
    readData();
    checkVal("R3", {8'h0, rdData}, 16'h0000);

    // Flags travel with their characters
    curReq = "R5";
    putChar(8'h11, 1'b0, 1'b1, 1'b0);
    putChar(8'h22, 1'b1, 1'b0, 1'b1);
    readStat();
    checkVal("R4", statusNow(), 16'h2);
    readStat();
    checkVal("R4", statusNow(), 16'h2);
    readData();
    checkVal("R5", {8'h0, rdData}, 16'h0011);
    readStat();
    checkVal("R5", statusNow(), 16'h5);
    readData();
    checkVal("R5", {8'h0, rdData}, 16'h0022);
    checkVal("R2", {15'h0, rxComplete}, 16'h0);

    // Third character waits and follows in order
    curReq = "R1";
    putChar(8'h31, 1'b0, 1'b0, 1'b0);
    putChar(8'h32, 1'b0, 1'b0, 1'b0);
    putChar(8'h33, 1'b1, 1'b0, 1'b0);
    readData();
    checkVal("R1", {8'h0, rdData}, 16'h0031);
    readData();
    checkVal("R1", {8'h0, rdData}, 16'h0032);
    readStat();
    checkVal("R1", statusNow(), 16'h1);
    readData();
    checkVal("R1", {8'h0, rdData}, 16'h0033);
    checkVal("R1", {15'h0, rxComplete}, 16'h0);

    // Overrun
    curReq = "R6";
    putChar(8'h41, 1'b0, 1'b0, 1'b0);
    putChar(8'h42, 1'b0, 1'b0, 1'b0);
    putChar(8'h43, 1'b0, 1'b0, 1'b0);
    startBit();
    readStat();
    checkVal("R6", statusNow(), 16'h0);
    readData();
    readStat();
    checkVal("R6", statusNow(), 16'h8);
    readData();
    checkVal("R6", {8'h0, rdData}, 16'h0042);
    checkVal("R6", {15'h0, rxComplete}, 16'h0);
    putChar(8'h44, 1'b0, 1'b0, 1'b0);
    readStat();
    checkVal("R6", statusNow(), 16'h0);
    readData();

    // Start bits that must not flag overrun
    curReq = "R8";
    putChar(8'h51, 1'b0, 1'b0, 1'b0);
    putChar(8'h52, 1'b0, 1'b0, 1'b0);
    startBit();
    readStat();
    checkVal("R8", statusNow(), 16'h0);
    readData();
    readStat();
    checkVal("R8", statusNow(), 16'h0);
    readData();
    putChar(8'h61, 1'b0, 1'b0, 1'b0);
    putChar(8'h62, 1'b0, 1'b0, 1'b0);
    putChar(8'h63, 1'b0, 1'b0, 1'b0);
    dataRead = 1'b1; startDetect = 1'b1;
    @(negedge clk);
    dataRead = 1'b0; startDetect = 1'b0;
    readStat();
    checkVal("R8", statusNow(), 16'h0);
    readData();
    checkVal("R8", {8'h0, rdData}, 16'h0062);
    readData();
    checkVal("R8", {8'h0, rdData}, 16'h0063);

    // Receiver disable flushes
    curReq = "R7";
    putChar(8'h71, 1'b1, 1'b1, 1'b1);
    putChar(8'h72, 1'b0, 1'b0, 1'b0);
    putChar(8'h73, 1'b0, 1'b0, 1'b0);
    rxEnable = 1'b0;
    @(negedge clk);
    checkVal("R7", {15'h0, rxComplete}, 16'h0);
    putChar(8'h7A, 1'b1, 1'b0, 1'b0);
    checkVal("R7", {15'h0, rxComplete}, 16'h0);
    rxEnable = 1'b1;
    readStat();
    checkVal("R7", statusNow(), 16'h0);
    putChar(8'h74, 1'b0, 1'b0, 1'b0);
    readData();
    checkVal("R7", {8'h0, rdData}, 16'h0074);
    checkVal("R7", {15'h0, rxComplete}, 16'h0);

    // Read-return registers hold without strobes
    curReq = "R10";
    keep = rdData;
    putChar(8'h81, 1'b1, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    checkVal("R10", {8'h0, rdData}, {8'h0, keep});
    checkVal("R10", statusNow(), 16'h0);
    readData();

    // Random traffic within the front-end rules
    for (int i = 0; i < 3000; i++) begin
      int unsigned r;
      r = $urandom(seed);
      seed = seed * 32'd1103515245 + 32'd12345;
      rxEnable      = (r[5:0] != 6'd0);
      statusRead    = r[6] & r[7];
      dataRead      = r[8] & r[9] & r[15];
      charData      = r[23:16];
      charBit8      = r[24];
      charFrameErr  = r[25] & r[26];
      charParityErr = r[27] & r[28];
      charValid     = 1'b0;
      startDetect   = 1'b0;
      if (r[10] && !mHold) charValid = 1'b1;
      else if (r[11] && r[12]) startDetect = 1'b1;
      @(negedge clk);
    end
    charValid = 1'b0; startDetect = 1'b0; statusRead = 1'b0; dataRead = 1'b0; rxEnable = 1'b1;
    @(negedge clk);
    checking = 1'b0;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule